// File: doc/BRIEF.md
# Multicycle Instruction Step Controller

This block is the control unit of a multicycle processor datapath. The datapath has one shared memory for instructions and data, a single ALU, and internal holding registers: the instruction register, the memory data register, the two operand latches and the ALU result latch. Each instruction runs through a sequence of steps, one step per clock. The step sequence is fetch, decode, execute, memory access and write-back. Each instruction class leaves that sequence at a different step, so an instruction takes between three and five clocks.

The controller holds the current step in a state register. It takes the opcode field from the instruction register and the ALU zero flag. In every clock it drives the datapath's multiplexer selects, write enables and ALU mode. Apart from the conditional program-counter load, the control points depend only on the current step. The opcode only steers which step comes next. Five instruction classes are decoded: register-register ALU operations, word load, word store, branch-if-equal and unconditional jump.

Top module: `mc_ctrl`

## Requirements
- R1: While reset is asserted and in the first clock after it, the controller is in the fetch step (R2's control pattern).
- R2: The fetch step drives ir_we=1, mem_rd=1, pc_we=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01 (constant 4), alu_mode=00 and pc_src=00. Every control not listed is 0, and pc_en=1. The next step is always decode.
- R3: The decode step drives alu_a_sel=0, alu_b_sel=11 (shifted sign-extended offset) and alu_mode=00, with every other control 0. The opcode is decoded here.
- R4: A load (opcode 6'h23) takes 5 clocks. In step 3, alu_a_sel=1 and alu_b_sel=10 (sign-extended offset) form the address. In step 4, mem_rd=1 and addr_sel=1. In step 5, rf_we=1, wb_sel=1 (memory data register) and dst_sel=0. Fetch follows.
- R5: A store (opcode 6'h2B) takes 4 clocks. Step 3 matches R4's address step. In step 4, mem_wr=1 and addr_sel=1, with rf_we=0. Fetch follows.
- R6: A register ALU operation (opcode 6'h00) takes 4 clocks. In step 3, alu_a_sel=1, alu_b_sel=00 and alu_mode=10 (function field decides). In step 4, rf_we=1, dst_sel=1 and wb_sel=0. Fetch follows.
- R7: A branch (opcode 6'h04) takes 3 clocks. In step 3, pc_we_cond=1, alu_a_sel=1, alu_b_sel=00, alu_mode=01 (subtract) and pc_src=01. pc_en is 1 in that step exactly when alu_zero is 1.
- R8: A jump (opcode 6'h02) takes 3 clocks. In step 3, pc_we=1 and pc_src=10, with every other control 0, and pc_en=1.
- R9: Any other opcode returns from decode straight to fetch, so the instruction takes 2 clocks and writes nothing.
- R10: In no clock are mem_rd and mem_wr both 1. ir_we is only ever 1 together with mem_rd=1 and addr_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| ir_we | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 program counter, 1 ALU result latch |
| wb_sel | output | 1 | Register write data: 0 ALU result latch, 1 memory data register |
| pc_we | output | 1 | Unconditional program counter load |
| pc_we_cond | output | 1 | Program counter load when the ALU result is zero |
| pc_en | output | 1 | Combined program counter load enable |
| dst_sel | output | 1 | Destination register: 0 second source field, 1 destination field |
| rf_we | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU A: 0 program counter, 1 A latch |
| alu_b_sel | output | 2 | ALU B: 00 B latch, 01 four, 10 offset, 11 offset shifted by 2 |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 result latch, 10 jump target |

## Verification
The assertions check, on every cycle, the properties that hold in any state. Memory is never read and written in the same cycle. An instruction register load always comes with a memory read from the program counter address. A store cycle always addresses through the result latch. Fetch is always followed by decode. A register write, a branch step or a jump step always returns to fetch. The bench's directed scenarios show the full control pattern of each step, the exact length of each instruction class, the dependence of the branch load on the zero flag, and how undefined opcodes are handled.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W  = 6;
  localparam int SEL_W = 2;

  localparam logic [OP_W-1:0] OP_RALU  = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BREQ  = 6'h04;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_RDMEM, S_WRMEM,
    S_LDBACK, S_REXEC, S_RBACK, S_BRANCH, S_JUMP
  } step_e;

  typedef enum logic [2:0] {
    K_ALU, K_LOAD, K_STORE, K_BRANCH, K_JUMP, K_BAD
  } kind_e;

  typedef struct packed {
    logic             ir_we;
    logic             mem_rd;
    logic             mem_wr;
    logic             addr_sel;
    logic             wb_sel;
    logic             pc_we;
    logic             pc_we_cond;
    logic             dst_sel;
    logic             rf_we;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_mode;
    logic [SEL_W-1:0] pc_src;
  } ctrl_t;

  function automatic kind_e classify(input logic [OP_W-1:0] op);
    kind_e k;
    case (op)
      OP_RALU:  k = K_ALU;
      OP_LOAD:  k = K_LOAD;
      OP_STORE: k = K_STORE;
      OP_BREQ:  k = K_BRANCH;
      OP_JUMP:  k = K_JUMP;
      default:  k = K_BAD;
    endcase
    return k;
  endfunction

  function automatic logic pc_load(input logic uncond, input logic cond,
                                   input logic zero);
    return uncond | (cond & zero);
  endfunction
endpackage

// File: rtl/mc_step_seq.sv
module mc_step_seq
  import mc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output step_e           step,
  output logic            instr_last
);
  step_e nxt;
  kind_e kind;

  assign kind = classify(opcode);

  always_comb begin
    nxt = S_FETCH;
    case (step)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (kind)
          K_LOAD, K_STORE: nxt = S_ADDR;
          K_ALU:           nxt = S_REXEC;
          K_BRANCH:        nxt = S_BRANCH;
          K_JUMP:          nxt = S_JUMP;
          default:         nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (kind == K_STORE) ? S_WRMEM : S_RDMEM;
      S_RDMEM:  nxt = S_LDBACK;
      S_REXEC:  nxt = S_RBACK;
      default:  nxt = S_FETCH;
    endcase
  end

  // event wire: the current step is the final one of this instruction
  assign instr_last = (nxt == S_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= S_FETCH;
    else        step <= nxt;
  end

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == S_FETCH |=> step == S_DECODE);
  // R9
  bad_op_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == S_DECODE && kind == K_BAD) |=> step == S_FETCH);
  // R4
  load_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step == S_RDMEM |=> step == S_LDBACK);
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  step_e step,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;
    case (step)
      S_FETCH: begin
        ctl.ir_we     = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      S_RDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_WRMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_LDBACK: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      S_REXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_mode  = 2'b10;
      end
      S_RBACK: begin
        ctl.rf_we   = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      S_BRANCH: begin
        ctl.pc_we_cond = 1'b1;
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_mode   = 2'b01;
        ctl.pc_src     = 2'b01;
      end
      S_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_src = 2'b10;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  input  logic             alu_zero,
  output logic             ir_we,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             wb_sel,
  output logic             pc_we,
  output logic             pc_we_cond,
  output logic             pc_en,
  output logic             dst_sel,
  output logic             rf_we,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] alu_mode,
  output logic [SEL_W-1:0] pc_src
);
  step_e step;
  logic  instr_last;
  ctrl_t ctl;

  mc_step_seq u_seq (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .step(step), .instr_last(instr_last)
  );

  mc_ctrl_decode u_dec (.step(step), .ctl(ctl));

  assign ir_we      = ctl.ir_we;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign addr_sel   = ctl.addr_sel;
  assign wb_sel     = ctl.wb_sel;
  assign pc_we      = ctl.pc_we;
  assign pc_we_cond = ctl.pc_we_cond;
  assign dst_sel    = ctl.dst_sel;
  assign rf_we      = ctl.rf_we;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign alu_mode   = ctl.alu_mode;
  assign pc_src     = ctl.pc_src;
  assign pc_en      = pc_load(ctl.pc_we, ctl.pc_we_cond, alu_zero);

  // R10
  one_mem_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R10
  ir_load_from_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |-> (mem_rd && !addr_sel));
  // R5
  store_addr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> addr_sel);
  // R6
  regwrite_ends_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> instr_last);
  // R7
  branch_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_cond |=> ir_we);
  // R8
  jump_refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !ir_we) |=> ir_we);
endmodule

// File: tb/mc_ctrl_bench.sv
module mc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic       alu_zero = 1'b0;
  logic ir_we, mem_rd, mem_wr, addr_sel, wb_sel, pc_we, pc_we_cond, pc_en;
  logic dst_sel, rf_we, alu_a_sel;
  logic [1:0] alu_b_sel, alu_mode, pc_src;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  mc_ctrl u_mc_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
    .ir_we(ir_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
    .wb_sel(wb_sel), .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_en(pc_en),
    .dst_sel(dst_sel), .rf_we(rf_we), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_mode(alu_mode), .pc_src(pc_src)
  );

  // expected patterns, fields: ir rd wr addr wb pcwe pcc dst rf a b[2] mode[2] src[2]
  localparam logic [15:0] P_FETCH  = 16'b1100_0100_00_01_00_00;
  localparam logic [15:0] P_DEC    = 16'b0000_0000_00_11_00_00;
  localparam logic [15:0] P_ADDR   = 16'b0000_0000_01_10_00_00;
  localparam logic [15:0] P_RDMEM  = 16'b0101_0000_00_00_00_00;
  localparam logic [15:0] P_WRMEM  = 16'b0011_0000_00_00_00_00;
  localparam logic [15:0] P_LDBACK = 16'b0000_1000_10_00_00_00;
  localparam logic [15:0] P_REXEC  = 16'b0000_0000_01_00_10_00;
  localparam logic [15:0] P_RBACK  = 16'b0000_0001_10_00_00_00;
  localparam logic [15:0] P_BR     = 16'b0000_0010_01_00_01_01;
  localparam logic [15:0] P_JMP    = 16'b0000_0100_00_00_00_10;

  function automatic logic [15:0] seen();
    return {ir_we, mem_rd, mem_wr, addr_sel, wb_sel, pc_we, pc_we_cond,
            dst_sel, rf_we, alu_a_sel, alu_b_sel, alu_mode, pc_src};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 in reset", seen(), P_FETCH);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 after reset", seen(), P_FETCH);
  endtask

  task automatic t_load();
    opcode = 6'h23;
    chk("R2 fetch", seen(), P_FETCH);
    chk("R2 pc_en", {15'd0, pc_en}, 16'd1);
    nxt(); chk("R3 decode", seen(), P_DEC);
    chk("R3 pc_en", {15'd0, pc_en}, 16'd0);
    nxt(); chk("R4 addr", seen(), P_ADDR);
    nxt(); chk("R4 read", seen(), P_RDMEM);
    nxt(); chk("R4 writeback", seen(), P_LDBACK);
    nxt(); chk("R4 refetch after 5", seen(), P_FETCH);
  endtask

  task automatic t_store();
    opcode = 6'h2B;
    nxt(); chk("R5 decode", seen(), P_DEC);
    nxt(); chk("R5 addr", seen(), P_ADDR);
    nxt(); chk("R5 write", seen(), P_WRMEM);
    nxt(); chk("R5 refetch after 4", seen(), P_FETCH);
  endtask

  task automatic t_ralu();
    opcode = 6'h00;
    nxt(); chk("R6 decode", seen(), P_DEC);
    nxt(); chk("R6 exec", seen(), P_REXEC);
    nxt(); chk("R6 writeback", seen(), P_RBACK);
    nxt(); chk("R6 refetch after 4", seen(), P_FETCH);
  endtask

  task automatic t_branch(input logic z);
    opcode = 6'h04;
    alu_zero = z;
    nxt(); chk("R7 decode", seen(), P_DEC);
    nxt(); chk("R7 compare", seen(), P_BR);
    chk("R7 pc_en vs zero", {15'd0, pc_en}, {15'd0, z});
    alu_zero = ~z; #1;
    chk("R7 pc_en follows zero", {15'd0, pc_en}, {15'd0, ~z});
    alu_zero = 1'b0;
    nxt(); chk("R7 refetch after 3", seen(), P_FETCH);
  endtask

  task automatic t_jump();
    opcode = 6'h02;
    nxt(); chk("R8 decode", seen(), P_DEC);
    nxt(); chk("R8 jump", seen(), P_JMP);
    chk("R8 pc_en", {15'd0, pc_en}, 16'd1);
    nxt(); chk("R8 refetch after 3", seen(), P_FETCH);
  endtask

  task automatic t_bad(input logic [5:0] op);
    opcode = op;
    nxt(); chk("R9 decode", seen(), P_DEC);
    nxt(); chk("R9 refetch after 2", seen(), P_FETCH);
  endtask

  // R10 exclusive memory use observed across all scenarios
  always @(negedge clk) if (rst_n && !done) begin
    if (mem_rd && mem_wr) begin
      n_fail++;
      $display("FAIL R10: actual rd=%0b wr=%0b expected exclusive", mem_rd, mem_wr);
    end
  end

  initial begin
    t_reset();
    t_load();
    t_store();
    t_ralu();
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_bad(6'h3F);
    t_bad(6'h22);
    t_load();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule